// File: doc/BRIEF.md
# Chained Debug Trigger Matcher

This block holds ten programmable debug triggers and tests them, each cycle, against the access made by the current instruction. Each trigger watches one access class: instruction fetch, load, or store. A store trigger can compare either the store address or the store data. The triggers are grouped as five fixed pairs: (fetch, fetch), (store, store), (load, load), (fetch, store) and (fetch, load). Triggers 2g and 2g+1 form pair g. A pair can be chained so that it fires only when both of its halves match. The block then reports which triggers fired, whether any fired, and whether the trap is taken on the next instruction or on the current one.

Configuration comes in through one write port with a valid qualifier and a trigger index. At most one trigger is written per cycle, and the new settings are used from the following cycle. The match outputs are combinational from the access inputs and the stored settings. A clear input masks them, for example when the instruction is being flushed. Delivering the exception, flushing the pipeline and saving the return address are left to the surrounding logic.

Top module: `trig_match_unit`

## Requirements
- R1: After reset every trigger is disabled, so no hit is reported for any input until a trigger is written with its enable bit set.
- R2: A write with `wrValid` high stores `wrEnable`, `wrMatch`, `wrSelData`, `wrTiming`, `wrChain` and `wrTdata` into trigger `wrIdx` (0 to 9). The new settings govern the outputs from the cycle after the clock edge that captures the write.
- R3: Trigger kinds are fixed by index: 0, 1, 6 and 8 are fetch triggers, 2, 3 and 7 are store triggers, and 4, 5 and 9 are load triggers. A fetch trigger compares `fetchAddr`. A load trigger compares `loadAddr`. A store trigger compares `storeAddr` when its select bit is 0 and `storeData` when it is 1. A trigger can hit only while the valid input of its own class is high.
- R4: The match code compares the observed value v against the stored value c as unsigned numbers. Code 0 matches when v == c, code 2 when v >= c, and code 3 when v < c. Code 1 never matches.
- R5: A load trigger with its select bit set (a data compare) never hits.
- R6: Pair g is chained when the chain bit of trigger 2g is set. A chained pair fires both of its triggers together, and only when both halves match in the same cycle. An unchained pair lets each trigger fire on its own.
- R7: If the two halves of a chained pair hold different timing bits, neither trigger of the pair fires.
- R8: The store-store pair (triggers 2 and 3) is always treated as unchained, whatever its chain bit holds.
- R9: A trigger whose enable bit is 0 never hits. In a chained pair, a disabled half also stops its partner from firing.
- R10: `anyHit` is the OR of all bits of `hitVec`. `trapNext` is high only when at least one trigger fires and every firing trigger has timing 1 (trap on the next instruction). If any firing trigger has timing 0, the trap is taken on the current instruction and `trapNext` is 0.
- R11: While `clear` is high, `hitVec`, `anyHit` and `trapNext` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Configuration write strobe |
| wrIdx | input | 4 | Index of the trigger to write |
| wrEnable | input | 1 | Trigger enable |
| wrMatch | input | 2 | Match code (0 eq, 2 ge, 3 lt, 1 never) |
| wrSelData | input | 1 | 1 selects a data compare, 0 an address compare |
| wrTiming | input | 1 | 0 traps on the current instruction, 1 on the next |
| wrChain | input | 1 | Chain bit (used on even triggers only) |
| wrTdata | input | 64 | Compare value |
| fetchValid | input | 1 | A fetch access is present |
| fetchAddr | input | 64 | Fetch address |
| loadValid | input | 1 | A load access is present |
| loadAddr | input | 64 | Load address |
| storeValid | input | 1 | A store access is present |
| storeAddr | input | 64 | Store address |
| storeData | input | 64 | Store data |
| clear | input | 1 | Masks all hit outputs this cycle |
| hitVec | output | 10 | Per-trigger fire vector |
| anyHit | output | 1 | At least one trigger fired |
| trapNext | output | 1 | Trap on the next instruction rather than the current one |

## Verification
Random configurations and accesses are drawn from a small set of nearby values. This makes equality, greater-or-equal and less-than compares land on both sides of their boundaries. It also makes both halves of a pair match together often enough to exercise chaining. Directed cases cover the following:
- whether the store select bit chooses address or data, and whether the load data compare is suppressed;
- whether chaining requires both halves and equal timing, and whether the store-store pair ignores its chain bit;
- whether a disabled partner blocks a chained pair;
- whether timing resolves toward the current instruction when firing triggers hold mixed timing bits.

A final directed case checks that `clear` masks a hit that would otherwise be reported.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_PAIRS = 5;
  localparam int NUM_TRIG  = 2 * NUM_PAIRS;
  localparam int IDX_W     = $clog2(NUM_TRIG);
  localparam int DATA_W    = 64;

  typedef enum logic [1:0] {KIND_FETCH, KIND_STORE, KIND_LOAD} kind_e;

  typedef struct packed {
    logic              enable;
    logic [1:0]        matchType;
    logic              selData;
    logic              timing;
    logic              chain;
    logic [DATA_W-1:0] tdata;
  } trig_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TRIG-1:0] load;
    logic                squash;
    trig_cfg_t           fields;
  } ctl_strobe_t;

  // fixed pair layout: (F,F) (S,S) (L,L) (F,S) (F,L)
  function automatic kind_e trigKind(input int t);
    case (t)
      0, 1, 6, 8: trigKind = KIND_FETCH;
      2, 3, 7:    trigKind = KIND_STORE;
      default:    trigKind = KIND_LOAD;
    endcase
  endfunction

  function automatic logic cmpMatch(input logic [1:0] code,
                                    input logic [DATA_W-1:0] v,
                                    input logic [DATA_W-1:0] c);
    case (code)
      2'd0:    cmpMatch = (v == c);
      2'd2:    cmpMatch = (v >= c);
      2'd3:    cmpMatch = (v < c);
      default: cmpMatch = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
(
  input  logic             wrValid,
  input  logic [IDX_W-1:0] wrIdx,
  input  trig_cfg_t        wrFields,
  input  logic             clear,
  output ctl_strobe_t      strobe
);
  always_comb begin
    strobe.fields = wrFields;
    strobe.squash = clear;
    for (int t = 0; t < NUM_TRIG; t++) begin
      strobe.load[t] = wrValid && (wrIdx == IDX_W'(t));
    end
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadAddr,
  input  logic              storeValid,
  input  logic [DATA_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  output logic [NUM_TRIG-1:0] hitVec,
  output logic              anyHit,
  output logic              trapNext
);
  trig_cfg_t           cfgQ [NUM_TRIG];
  logic [NUM_TRIG-1:0] raw;
  logic [NUM_TRIG-1:0] timVec;
  logic [NUM_TRIG-1:0] fire;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    localparam kind_e KIND = trigKind(t);
    logic [DATA_W-1:0] operand;
    logic              classOk;

    always_ff @(posedge clk) begin
      if (!rstN) cfgQ[t] <= '0;
      else if (strobe.load[t]) cfgQ[t] <= strobe.fields;
    end

    if (KIND == KIND_FETCH) begin : g_fetch
      assign operand = fetchAddr;
      assign classOk = fetchValid;
    end else if (KIND == KIND_STORE) begin : g_store
      assign operand = cfgQ[t].selData ? storeData : storeAddr;
      assign classOk = storeValid;
    end else begin : g_load
      assign operand = loadAddr;
      assign classOk = loadValid && !cfgQ[t].selData;
    end

    assign raw[t]    = cfgQ[t].enable && classOk &&
                       cmpMatch(cfgQ[t].matchType, operand, cfgQ[t].tdata);
    assign timVec[t] = cfgQ[t].timing;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam bit NO_CHAIN = (trigKind(2*g) == KIND_STORE) &&
                              (trigKind(2*g+1) == KIND_STORE);
    logic chained;
    logic both;
    assign chained = cfgQ[2*g].chain && !NO_CHAIN;
    assign both    = raw[2*g] && raw[2*g+1] && (timVec[2*g] == timVec[2*g+1]);
    assign fire[2*g]   = chained ? both : raw[2*g];
    assign fire[2*g+1] = chained ? both : raw[2*g+1];
  end

  assign hitVec   = strobe.squash ? '0 : fire;
  assign anyHit   = |hitVec;
  assign trapNext = anyHit && !(|(hitVec & ~timVec));
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrEnable,
  input  logic [1:0]        wrMatch,
  input  logic              wrSelData,
  input  logic              wrTiming,
  input  logic              wrChain,
  input  logic [DATA_W-1:0] wrTdata,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadAddr,
  input  logic              storeValid,
  input  logic [DATA_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic              clear,
  output logic [NUM_TRIG-1:0] hitVec,
  output logic              anyHit,
  output logic              trapNext
);
  trig_cfg_t   wrFields;
  ctl_strobe_t strobe;

  assign wrFields = '{enable: wrEnable, matchType: wrMatch, selData: wrSelData,
                      timing: wrTiming, chain: wrChain, tdata: wrTdata};

  trig_ctrl u_ctrl (
    .wrValid (wrValid),
    .wrIdx   (wrIdx),
    .wrFields(wrFields),
    .clear   (clear),
    .strobe  (strobe)
  );

  trig_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fetchValid(fetchValid),
    .fetchAddr (fetchAddr),
    .loadValid (loadValid),
    .loadAddr  (loadAddr),
    .storeValid(storeValid),
    .storeAddr (storeAddr),
    .storeData (storeData),
    .hitVec    (hitVec),
    .anyHit    (anyHit),
    .trapNext  (trapNext)
  );
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk
  import trig_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrValid,
  input logic [IDX_W-1:0]    wrIdx,
  input logic                wrEnable,
  input logic                wrSelData,
  input logic                clear,
  input logic [NUM_TRIG-1:0] hitVec,
  input logic                anyHit,
  input logic                trapNext
);
  // R11
  clear_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> (hitVec == '0) && !anyHit && !trapNext);

  // R10
  trap_next_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapNext |-> anyHit);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (hitVec == '0));

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_t
    // R9
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrValid && wrIdx == IDX_W'(t) && !wrEnable) |=> !hitVec[t]);
    if (trigKind(t) == KIND_LOAD) begin : g_ld
      // R5
      load_data_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
        (wrValid && wrIdx == IDX_W'(t) && wrSelData) |=> !hitVec[t]);
    end
  end
endmodule

bind trig_match_unit trig_match_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrValid  (wrValid),
  .wrIdx    (wrIdx),
  .wrEnable (wrEnable),
  .wrSelData(wrSelData),
  .clear    (clear),
  .hitVec   (hitVec),
  .anyHit   (anyHit),
  .trapNext (trapNext)
);

// File: tb/sim_trig_match_unit.sv
module sim_trig_match_unit;
  import trig_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, wrValid, wrEnable, wrSelData, wrTiming, wrChain;
  logic [3:0]  wrIdx;
  logic [1:0]  wrMatch;
  logic [63:0] wrTdata;
  logic        fetchValid, loadValid, storeValid, clear;
  logic [63:0] fetchAddr, loadAddr, storeAddr, storeData;
  logic [9:0]  hitVec;
  logic        anyHit, trapNext;

  trig_match_unit u0 (.*);

  logic        bEn [10];
  logic [1:0]  bMt [10];
  logic        bSel[10], bTim[10], bCh[10];
  logic [63:0] bVal[10];
  int nChk = 0, nBad = 0;
  bit done = 0;

  // 0 fetch, 1 store, 2 load
  function automatic int bKind(int t);
    if (t == 0 || t == 1 || t == 6 || t == 8) return 0;
    if (t == 2 || t == 3 || t == 7) return 1;
    return 2;
  endfunction

  function automatic logic bCmp(logic [1:0] m, logic [63:0] v, logic [63:0] c);
    if (m == 2'd0) return v == c;
    if (m == 2'd2) return v >= c;
    if (m == 2'd3) return v < c;
    return 1'b0;
  endfunction

  function automatic logic [9:0] model();
    logic [9:0] raw, fire;
    for (int t = 0; t < 10; t++) begin
      logic [63:0] op; logic ok;
      if (bKind(t) == 0) begin op = fetchAddr; ok = fetchValid; end
      else if (bKind(t) == 1) begin op = bSel[t] ? storeData : storeAddr; ok = storeValid; end
      else begin op = loadAddr; ok = loadValid && !bSel[t]; end
      raw[t] = bEn[t] && ok && bCmp(bMt[t], op, bVal[t]);
    end
    for (int g = 0; g < 5; g++) begin
      if (bCh[2*g] && g != 1) begin
        logic b;
        b = raw[2*g] && raw[2*g+1] && (bTim[2*g] == bTim[2*g+1]);
        fire[2*g] = b; fire[2*g+1] = b;
      end else begin
        fire[2*g] = raw[2*g]; fire[2*g+1] = raw[2*g+1];
      end
    end
    return clear ? 10'd0 : fire;
  endfunction

  task automatic wr(int idx, logic en, logic [1:0] m, logic sel, logic tim, logic ch,
                    logic [63:0] val);
    @(negedge clk);
    wrValid = 1; wrIdx = 4'(idx); wrEnable = en; wrMatch = m; wrSelData = sel;
    wrTiming = tim; wrChain = ch; wrTdata = val;
    @(negedge clk);
    wrValid = 0;
    bEn[idx] = en; bMt[idx] = m; bSel[idx] = sel; bTim[idx] = tim; bCh[idx] = ch;
    bVal[idx] = val;
  endtask

  task automatic chk(string tag, logic fv, logic [63:0] fa, logic lv, logic [63:0] la,
                     logic sv, logic [63:0] sa, logic [63:0] sd, logic clr);
    logic [9:0] eh; logic ea, et;
    fetchValid = fv; fetchAddr = fa; loadValid = lv; loadAddr = la;
    storeValid = sv; storeAddr = sa; storeData = sd; clear = clr;
    #2;
    eh = model();
    ea = |eh;
    et = 1'b0;
    if (ea) begin
      et = 1'b1;
      for (int t = 0; t < 10; t++) if (eh[t] && !bTim[t]) et = 1'b0;
    end
    nChk++;
    if (hitVec !== eh || anyHit !== ea || trapNext !== et) begin
      nBad++;
      $display("FAIL %s: hitVec=%b anyHit=%b trapNext=%b expected %b %b %b",
               tag, hitVec, anyHit, trapNext, eh, ea, et);
    end
    @(negedge clk);
  endtask

  task automatic expectHits(string tag, logic [9:0] want);
    nChk++;
    if (hitVec !== want) begin
      nBad++;
      $display("FAIL %s: hitVec=%b expected %b", tag, hitVec, want);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd1357);
    for (int t = 0; t < 10; t++) begin
      bEn[t] = 0; bMt[t] = 0; bSel[t] = 0; bTim[t] = 0; bCh[t] = 0; bVal[t] = 0;
    end
    rstN = 0; wrValid = 0; wrIdx = 0; wrEnable = 0; wrMatch = 0; wrSelData = 0;
    wrTiming = 0; wrChain = 0; wrTdata = 0;
    fetchValid = 0; loadValid = 0; storeValid = 0; clear = 0;
    fetchAddr = 0; loadAddr = 0; storeAddr = 0; storeData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: all disabled, zero compare values would match on equality if enabled
    chk("R1 reset", 1, 64'h0, 1, 64'h0, 1, 64'h0, 64'h0, 0);
    expectHits("R1 reset explicit", 10'd0);

    // R2 R3 R4: fetch equality, timing 0
    wr(0, 1, 2'd0, 0, 0, 0, 64'h1000);
    chk("R2 eq hit", 1, 64'h1000, 0, 0, 0, 0, 0, 0);
    chk("R4 eq miss", 1, 64'h1001, 0, 0, 0, 0, 0, 0);
    chk("R3 fetch invalid", 0, 64'h1000, 0, 0, 0, 0, 0, 0);
    // R4 ge with timing 1 -> R10 trapNext
    wr(1, 1, 2'd2, 0, 1, 0, 64'h2000);
    chk("R4 ge boundary", 1, 64'h2000, 0, 0, 0, 0, 0, 0);
    chk("R4 ge below", 1, 64'h1fff, 0, 0, 0, 0, 0, 0);
    // R10 mixed timing: trig0 (t0) and trig1 (t1) both hit
    wr(0, 1, 2'd2, 0, 0, 0, 64'h1000);
    chk("R10 mixed timing", 1, 64'h3000, 0, 0, 0, 0, 0, 0);
    // R4 code 1 never
    wr(0, 1, 2'd1, 0, 0, 0, 64'h1000);
    wr(1, 0, 2'd0, 0, 0, 0, 64'h0);
    chk("R4 code1", 1, 64'h1000, 0, 0, 0, 0, 0, 0);
    // R4 lt
    wr(6, 1, 2'd3, 0, 0, 0, 64'h500);
    chk("R4 lt below", 1, 64'h4ff, 0, 0, 0, 0, 0, 0);
    chk("R4 lt boundary", 1, 64'h500, 0, 0, 0, 0, 0, 0);
    wr(6, 0, 2'd0, 0, 0, 0, 64'h0);
    // R3 store address versus data select
    wr(2, 1, 2'd0, 1, 0, 0, 64'hab);
    chk("R3 store data", 0, 0, 0, 0, 1, 64'h77, 64'hab, 0);
    chk("R3 store data ignores addr", 0, 0, 0, 0, 1, 64'hab, 64'h77, 0);
    chk("R3 store invalid", 0, 0, 0, 0, 0, 64'h77, 64'hab, 0);
    // R8 store-store chain ignored
    wr(2, 1, 2'd0, 1, 0, 1, 64'hab);
    chk("R8 store pair unchained", 0, 0, 0, 0, 1, 64'h77, 64'hab, 0);
    expectHits("R8 explicit", 10'b0000000100);
    wr(2, 0, 2'd0, 0, 0, 0, 64'h0);
    // R5 load data compare never, load address works
    wr(4, 1, 2'd0, 1, 0, 0, 64'h40);
    wr(5, 1, 2'd0, 0, 0, 0, 64'h40);
    chk("R5 load data", 0, 0, 1, 64'h40, 0, 0, 0, 0);
    expectHits("R5 explicit", 10'b0000100000);
    wr(4, 0, 2'd0, 0, 0, 0, 64'h0);
    wr(5, 0, 2'd0, 0, 0, 0, 64'h0);
    // R6 chained fetch-store pair
    wr(6, 1, 2'd0, 0, 1, 1, 64'h900);
    wr(7, 1, 2'd0, 0, 1, 0, 64'h60);
    chk("R6 half match", 1, 64'h900, 0, 0, 1, 64'h61, 0, 0);
    chk("R6 both match", 1, 64'h900, 0, 0, 1, 64'h60, 0, 0);
    expectHits("R6 explicit", 10'b0011000000);
    // R7 differing timing
    wr(7, 1, 2'd0, 0, 0, 0, 64'h60);
    chk("R7 timing mismatch", 1, 64'h900, 0, 0, 1, 64'h60, 0, 0);
    expectHits("R7 explicit", 10'd0);
    // R11 clear masks a hit
    wr(7, 1, 2'd0, 0, 1, 0, 64'h60);
    chk("R11 clear", 1, 64'h900, 0, 0, 1, 64'h60, 0, 1);
    wr(6, 0, 2'd0, 0, 0, 0, 64'h0);
    wr(7, 0, 2'd0, 0, 0, 0, 64'h0);
    // R9 disabled partner blocks chained pair
    wr(8, 1, 2'd0, 0, 0, 1, 64'h700);
    wr(9, 0, 2'd0, 0, 0, 0, 64'h50);
    chk("R9 disabled partner", 1, 64'h700, 1, 64'h50, 0, 0, 0, 0);
    expectHits("R9 explicit", 10'd0);

    // random mix: R3 R4 R6 R7 R10 R11
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 0)
        wr($urandom_range(0, 9), 1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           64'(16 * $urandom_range(1, 3)));
      chk("R6 random", 1'($urandom_range(0, 1)), 64'(16 * $urandom_range(1, 3)),
          1'($urandom_range(0, 1)), 64'(16 * $urandom_range(1, 3)),
          1'($urandom_range(0, 1)), 64'(16 * $urandom_range(1, 3)),
          64'(16 * $urandom_range(1, 3)), 1'($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule